// File: doc/BRIEF.md
# Option-Byte Guard and Program Controller

This block sits between a register bus and the write port of a small on-chip flash region that holds configuration option half-words. It keeps that region behind two layers of protection. A main lock is released by a fixed two-word key sequence. An option-write enable is then armed by a second, separate two-word key sequence. Software then sets a program bit, sets a start bit, and issues one half-word write to the option region. The block launches that write on a simple request/done port towards the flash array.

The block keeps only the low byte of the written half-word. It replaces the high byte with the bitwise complement of the low byte, so every stored option half-word carries its own check pattern. A busy flag covers the time the array needs. An end-of-operation flag reports completion. Writes that arrive while the block is not ready are dropped and raise a write-error flag.

Top module: `optb_prog_ctrl`

## Requirements
- R1: After reset, the control register (offset 2) reads 0x1, meaning only the lock bit (bit 0) is set. The status register (offset 3) reads 0 and `fa_req` is low.
- R2: The lock bit clears only when 0x45670123 and then 0xCDEF89AB are written to the main key register (offset 0). Any other key write during the sequence returns it to its start.
- R3: The option-write enable (control bit 1) sets only when 0x45670123 and then 0xCDEF89AB are written to the option key register (offset 1) while the lock bit is clear. A wrong value, a wrong order, or a key write while locked restarts the sequence.
- R4: Writing the control register with bit 1 at 0 clears the option-write enable. Writing bit 1 as 1 never sets it.
- R5: Writing the control register with bit 0 at 1 sets the lock bit and clears the option-write enable in the same cycle. Writing bit 0 as 0 has no effect.
- R6: The program bit is control bit 2 and is written directly. The start bit is control bit 3. It sets only if the program bit was already 1 before that write. It clears when the program bit is written 0 or when an operation completes.
- R7: An accepted half-word write drives `fa_addr` with the write address and `fa_data` with {~low byte, low byte}. The upper byte of the written data is discarded.
- R8: One cycle after an accepted write, busy (status bit 0) and `fa_req` are high. They stay high until `fa_done`. On that edge, busy falls and end-of-operation (status bit 1) sets.
- R9: A half-word write is refused when the block is locked, the option-write enable is clear, the program or start bit is clear, or busy is set. A refused write sets the write-error flag (status bit 2) and leaves the array untouched.
- R10: Writing 1 to status bits 1 or 2 clears them, and a same-cycle set wins. Busy ignores status writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 main key, 1 option key, 2 control, 3 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| hw_we | input | 1 | Half-word write strobe to the option region |
| hw_addr | input | ADDR_W | Option half-word index |
| hw_wdata | input | 16 | Half-word write data |
| fa_req | output | 1 | Flash array write request, held until done |
| fa_addr | output | ADDR_W | Flash array half-word index |
| fa_data | output | 16 | Flash array data with complemented high byte |
| fa_done | input | 1 | One-cycle completion pulse from the array |

## Verification
The hardest case to reach is a second half-word write that arrives while the first one is still in flight in the array. That write must be refused without disturbing the held address and data. The bench reaches it by issuing two back-to-back writes right after arming start, using a flash model with a multi-cycle latency. It then checks the error flag, the untouched second location and the correctly stored first location. The key sequencers are driven through out-of-order and repeated-first-key patterns to show that a broken sequence must restart from its first word.

// File: rtl/optb_pkg.sv
package optb_pkg;
  localparam logic [1:0] OFS_MKEY = 2'd0;
  localparam logic [1:0] OFS_OKEY = 2'd1;
  localparam logic [1:0] OFS_CTRL = 2'd2;
  localparam logic [1:0] OFS_STAT = 2'd3;

  localparam int CB_LOCK  = 0;
  localparam int CB_WEN   = 1;
  localparam int CB_PROG  = 2;
  localparam int CB_START = 3;

  localparam int SB_BUSY = 0;
  localparam int SB_EOP  = 1;
  localparam int SB_WERR = 2;

  typedef enum logic [1:0] {
    KS_IDLE = 2'd0,
    KS_HALF = 2'd1,
    KS_OPEN = 2'd2
  } key_state_e;
endpackage

// File: rtl/optb_key_seq.sv
module optb_key_seq
  import optb_pkg::*;
#(
  parameter int          KW    = 32,
  parameter logic [KW-1:0] KEY_A = 32'h4567_0123,
  parameter logic [KW-1:0] KEY_B = 32'hCDEF_89AB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_we,
  input  logic [KW-1:0] key_data,
  input  logic          allow,
  input  logic          relock,
  output logic          open
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (relock) begin
      state_d = KS_IDLE;
    end else if (key_we) begin
      unique case (state_q)
        KS_IDLE: state_d = (allow && key_data == KEY_A) ? KS_HALF : KS_IDLE;
        KS_HALF: state_d = (allow && key_data == KEY_B) ? KS_OPEN : KS_IDLE;
        KS_OPEN: state_d = KS_OPEN;
        default: state_d = KS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KS_IDLE;
    else        state_q <= state_d;
  end

  assign open = (state_q == KS_OPEN);
endmodule

// File: rtl/optb_ctrl_bits.sv
module optb_ctrl_bits (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_we,
  input  logic wr_prog,
  input  logic wr_start,
  input  logic op_done,
  output logic prog,
  output logic start
);
  logic prog_q, prog_d;
  logic start_q, start_d;

  always_comb begin
    prog_d  = ctrl_we ? wr_prog : prog_q;
    start_d = start_q;
    if (op_done) begin
      start_d = 1'b0;
    end else if (ctrl_we) begin
      if (!wr_prog)                start_d = 1'b0;
      else if (wr_start && prog_q) start_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      prog_q  <= prog_d;
      start_q <= start_d;
    end
  end

  assign prog  = prog_q;
  assign start = start_q;
endmodule

// File: rtl/optb_prog_engine.sv
module optb_prog_engine #(
  parameter int ADDR_W = 4,
  parameter int HW_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_we,
  input  logic [ADDR_W-1:0] hw_addr,
  input  logic [HB_W-1:0]   hw_lo,
  input  logic              permit,
  input  logic              clr_eop,
  input  logic              clr_werr,
  input  logic              fa_done,
  output logic              busy,
  output logic              eop,
  output logic              werr,
  output logic              op_done,
  output logic              fa_req,
  output logic [ADDR_W-1:0] fa_addr,
  output logic [HW_W-1:0]   fa_data
);
  localparam int HB_W = HW_W / 2;

  logic busy_q, busy_d, eop_q, eop_d, werr_q, werr_d;
  logic [ADDR_W-1:0] addr_q;
  logic [HW_W-1:0]   data_q;
  logic accept, reject, finish;

  assign accept = hw_we && permit && !busy_q;
  assign reject = hw_we && !accept;
  assign finish = busy_q && fa_done;

  always_comb begin
    busy_d = busy_q;
    if (finish)      busy_d = 1'b0;
    else if (accept) busy_d = 1'b1;
    eop_d  = finish | (eop_q & ~clr_eop);
    werr_d = reject | (werr_q & ~clr_werr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      eop_q  <= 1'b0;
      werr_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      eop_q  <= eop_d;
      werr_q <= werr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '1;
    end else if (accept) begin
      addr_q <= hw_addr;
      data_q <= {~hw_lo, hw_lo};
    end
  end

  assign busy    = busy_q;
  assign eop     = eop_q;
  assign werr    = werr_q;
  assign op_done = finish;
  assign fa_req  = busy_q;
  assign fa_addr = addr_q;
  assign fa_data = data_q;
endmodule

// File: rtl/optb_prog_ctrl.sv
module optb_prog_ctrl
  import optb_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DW     = 32,
  parameter logic [DW-1:0] KEY_A = 32'h4567_0123,
  parameter logic [DW-1:0] KEY_B = 32'hCDEF_89AB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              hw_we,
  input  logic [ADDR_W-1:0] hw_addr,
  input  logic [15:0]       hw_wdata,
  output logic              fa_req,
  output logic [ADDR_W-1:0] fa_addr,
  output logic [15:0]       fa_data,
  input  logic              fa_done
);
  localparam int HW_W = 16;
  localparam int HB_W = HW_W / 2;

  logic [1:0] rsync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  logic mkey_we, okey_we, ctrl_we, stat_we;
  logic main_relock, opt_relock;
  logic main_open, opt_open;
  logic lock, opt_wen, prog, start;
  logic busy, eop, werr, op_done, permit;
  logic unused_hi;

  assign mkey_we = reg_we && (reg_addr == OFS_MKEY);
  assign okey_we = reg_we && (reg_addr == OFS_OKEY);
  assign ctrl_we = reg_we && (reg_addr == OFS_CTRL);
  assign stat_we = reg_we && (reg_addr == OFS_STAT);

  assign main_relock = ctrl_we && reg_wdata[CB_LOCK];
  assign opt_relock  = main_relock || (ctrl_we && !reg_wdata[CB_WEN]);

  optb_key_seq #(.KW(DW), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_main_keys (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .key_we   (mkey_we),
    .key_data (reg_wdata),
    .allow    (1'b1),
    .relock   (main_relock),
    .open     (main_open)
  );

  optb_key_seq #(.KW(DW), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_opt_keys (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .key_we   (okey_we),
    .key_data (reg_wdata),
    .allow    (main_open),
    .relock   (opt_relock),
    .open     (opt_open)
  );

  assign lock    = ~main_open;
  assign opt_wen = opt_open;

  optb_ctrl_bits u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ctrl_we  (ctrl_we),
    .wr_prog  (reg_wdata[CB_PROG]),
    .wr_start (reg_wdata[CB_START]),
    .op_done  (op_done),
    .prog     (prog),
    .start    (start)
  );

  assign permit    = main_open && opt_open && prog && start;
  assign unused_hi = ^hw_wdata[HW_W-1:HB_W];

  optb_prog_engine #(.ADDR_W(ADDR_W), .HW_W(HW_W)) u_engine (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .hw_we    (hw_we),
    .hw_addr  (hw_addr),
    .hw_lo    (hw_wdata[HB_W-1:0]),
    .permit   (permit),
    .clr_eop  (stat_we && reg_wdata[SB_EOP]),
    .clr_werr (stat_we && reg_wdata[SB_WERR]),
    .fa_done  (fa_done),
    .busy     (busy),
    .eop      (eop),
    .werr     (werr),
    .op_done  (op_done),
    .fa_req   (fa_req),
    .fa_addr  (fa_addr),
    .fa_data  (fa_data)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_CTRL: begin
        reg_rdata[CB_LOCK]  = lock;
        reg_rdata[CB_WEN]   = opt_wen;
        reg_rdata[CB_PROG]  = prog;
        reg_rdata[CB_START] = start;
      end
      OFS_STAT: begin
        reg_rdata[SB_BUSY] = busy;
        reg_rdata[SB_EOP]  = eop;
        reg_rdata[SB_WERR] = werr;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/optb_prog_ctrl_chk.sv
module optb_prog_ctrl_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hw_we,
  input logic              lock,
  input logic              opt_wen,
  input logic              prog,
  input logic              start,
  input logic              busy,
  input logic              eop,
  input logic              werr,
  input logic              fa_done,
  input logic [ADDR_W-1:0] fa_addr,
  input logic [15:0]       fa_data
);
  p_wen_needs_unlock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    opt_wen |-> !lock);

  p_start_needs_prog_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> prog);

  p_complement_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (fa_data[15:8] == ~fa_data[7:0]));

  p_hold_port_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fa_done) |=> ($stable(fa_data) && $stable(fa_addr)));

  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fa_done) |=> busy);

  p_done_eop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fa_done) |=> (!busy && eop));

  p_reject_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_we && (lock || !opt_wen)) |=> (werr && !$rose(busy)));
endmodule

bind optb_prog_ctrl optb_prog_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .hw_we   (hw_we),
  .lock    (lock),
  .opt_wen (opt_wen),
  .prog    (prog),
  .start   (start),
  .busy    (busy),
  .eop     (eop),
  .werr    (werr),
  .fa_done (fa_done),
  .fa_addr (fa_addr),
  .fa_data (fa_data)
);

// File: tb/optb_prog_ctrl_bench.sv
`timescale 1ns/1ps
module optb_prog_ctrl_bench;
  localparam int AW  = 4;
  localparam int LAT = 4;
  localparam logic [31:0] K1 = 32'h4567_0123;
  localparam logic [31:0] K2 = 32'hCDEF_89AB;

  // {addr[3:0], write data[15:0], expected stored[15:0]}
  localparam logic [35:0] VEC [0:5] = '{
    36'h0_1234_CB34, 36'h1_AA00_FF00, 36'h2_00FF_00FF,
    36'h3_5A5A_A55A, 36'h4_FFA5_5AA5, 36'h5_0001_FE01
  };

  logic clk, rst_n, reg_we, hw_we, fa_req, fa_done;
  logic [1:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [AW-1:0] hw_addr, fa_addr;
  logic [15:0] hw_wdata, fa_data;
  logic [15:0] mem [0:(1<<AW)-1];
  int lat_cnt, n_chk, n_bad, cyc;

  optb_prog_ctrl #(.ADDR_W(AW)) u_optb_prog_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_we(hw_we),
    .hw_addr(hw_addr), .hw_wdata(hw_wdata), .fa_req(fa_req),
    .fa_addr(fa_addr), .fa_data(fa_data), .fa_done(fa_done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // flash array model: fixed latency, one-cycle done pulse
  always @(posedge clk) begin
    if (fa_done) begin
      fa_done <= 1'b0;
      lat_cnt <= 0;
    end else if (fa_req) begin
      if (lat_cnt == LAT - 1) begin
        fa_done <= 1'b1;
        mem[fa_addr] <= fa_data;
      end else lat_cnt <= lat_cnt + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wr_hw(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    hw_we = 1'b1; hw_addr = a; hw_wdata = d;
    @(negedge clk);
    hw_we = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int k = 0; k < 40; k++) begin
      rd_reg(2'd3, s);
      if (s[0] == 1'b0) break;
    end
  endtask

  initial begin
    logic [31:0] r;
    n_chk = 0; n_bad = 0; cyc = 0; lat_cnt = 0; fa_done = 1'b0;
    reg_we = 0; reg_addr = 0; reg_wdata = 0; hw_we = 0; hw_addr = 0; hw_wdata = 0;
    for (int i = 0; i < (1<<AW); i++) mem[i] = 16'hFFFF;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd_reg(2'd2, r); check("R1 ctrl", r, 32'h1);
    rd_reg(2'd3, r); check("R1 status", r, 32'h0);
    check("R1 fa_req", {31'b0, fa_req}, 32'h0);

    // R3 option keys ignored while locked
    wr_reg(2'd1, K1); wr_reg(2'd1, K2);
    rd_reg(2'd2, r); check("R3 okeys while locked", r, 32'h1);

    // R2 broken main sequence, then proper one
    wr_reg(2'd0, K2); wr_reg(2'd0, K1); wr_reg(2'd0, 32'h0); wr_reg(2'd0, K2);
    rd_reg(2'd2, r); check("R2 broken main seq", r, 32'h1);
    wr_reg(2'd0, K1); wr_reg(2'd0, K2);
    rd_reg(2'd2, r); check("R2 main unlock", r, 32'h0);

    // R3 broken option sequence, then proper one
    wr_reg(2'd1, K2); wr_reg(2'd1, K1); wr_reg(2'd1, K1); wr_reg(2'd1, K2);
    rd_reg(2'd2, r); check("R3 broken opt seq", r, 32'h0);
    wr_reg(2'd1, K1); wr_reg(2'd1, K2);
    rd_reg(2'd2, r); check("R3 opt unlock", r, 32'h2);

    // R6 start refused when prog was clear before the write
    wr_reg(2'd2, 32'hE);
    rd_reg(2'd2, r); check("R6 start needs prior prog", r, 32'h6);

    // R7/R8 vector table walk
    for (int v = 0; v < 6; v++) begin
      logic [3:0]  a;
      logic [15:0] d, e;
      a = VEC[v][35:32]; d = VEC[v][31:16]; e = VEC[v][15:0];
      wr_reg(2'd2, 32'hE);
      wr_hw(a, d);
      rd_reg(2'd3, r); check("R8 busy after accept", r, 32'h1);
      check("R7 fa_data", {16'b0, fa_data}, {16'b0, e});
      check("R7 fa_addr", {28'b0, fa_addr}, {28'b0, a});
      wait_idle();
      rd_reg(2'd3, r); check("R8 eop at finish", r, 32'h2);
      check("R7 stored", {16'b0, mem[a]}, {16'b0, e});
      rd_reg(2'd2, r); check("R6 start cleared on done", r, 32'h6);
      wr_reg(2'd3, 32'h2);
      rd_reg(2'd3, r); check("R10 eop w1c", r, 32'h0);
    end

    // R9 write while busy is refused
    wr_reg(2'd2, 32'hE);
    wr_hw(4'd8, 16'h0011);
    wr_hw(4'd9, 16'h0022);
    wait_idle();
    rd_reg(2'd3, r); check("R9 busy collision flags", r, 32'h6);
    check("R9 busy collision untouched", {16'b0, mem[9]}, 32'hFFFF);
    check("R7 first write kept", {16'b0, mem[8]}, 32'hEE11);
    wr_reg(2'd3, 32'h6);
    rd_reg(2'd3, r); check("R10 both w1c", r, 32'h0);

    // R10 busy is read-only
    wr_reg(2'd3, 32'h1);
    rd_reg(2'd3, r); check("R10 busy read-only", r, 32'h0);

    // R9 prog clear
    wr_reg(2'd2, 32'h2);
    wr_hw(4'd10, 16'h0033);
    rd_reg(2'd3, r); check("R9 prog clear werr", r, 32'h4);
    check("R9 no request", {31'b0, fa_req}, 32'h0);
    wr_reg(2'd3, 32'h4);

    // R9 start clear
    wr_reg(2'd2, 32'h6);
    wr_hw(4'd10, 16'h0033);
    rd_reg(2'd3, r); check("R9 start clear werr", r, 32'h4);
    repeat (LAT + 2) @(negedge clk);
    check("R9 untouched", {16'b0, mem[10]}, 32'hFFFF);
    wr_reg(2'd3, 32'h4);

    // R4 option-write enable clear and no set by writing 1
    wr_reg(2'd2, 32'h4);
    rd_reg(2'd2, r); check("R4 wen cleared", r, 32'h4);
    wr_reg(2'd2, 32'h6);
    rd_reg(2'd2, r); check("R4 wen not set by write", r, 32'h4);
    wr_hw(4'd11, 16'h0044);
    rd_reg(2'd3, r); check("R9 wen clear werr", r, 32'h4);
    wr_reg(2'd3, 32'h4);

    // R5 relock clears option-write enable
    wr_reg(2'd1, K1); wr_reg(2'd1, K2);
    rd_reg(2'd2, r); check("R3 reopen", r, 32'h6);
    wr_reg(2'd2, 32'h6 | 32'h1);
    rd_reg(2'd2, r); check("R5 lock clears wen", r, 32'h5);
    wr_reg(2'd2, 32'h4);
    rd_reg(2'd2, r); check("R5 lock 0 write ignored", r, 32'h5);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule